// File: doc/BRIEF.md
# Serial-Bus Controlled Current-DAC Setting Registers

This block is an I2C target that holds the setting registers of a four-channel sink/source current DAC. A fast system clock oversamples the SCL and SDA lines. The block finds START and STOP conditions and compares the 7-bit device address with a value that arrives already decoded. It accepts single-byte register writes and register reads. It drives SDA only through an open-drain pull-down enable.

Each channel has a direction flag and a 5-bit magnitude. Together they form a sign-magnitude code, so one register spans 31 sink steps, zero and 31 source steps. A write is made of the device address with R/W=0, a memory address and one data byte. The memory address also sets the register pointer. A read is made of the device address with R/W=1 and one data byte, which the master closes with a NACK. The data comes from the register that the pointer selects.

A change on the device-address inputs cancels the transaction in progress and releases SDA. The channel settings are kept.

Top module: `dac_ctrl_i2c_slave`

## Requirements
- R1: A register byte holds the direction in bit 7 (1 = source, 0 = sink) and the magnitude in bits 4:0. Bits 6:5 are not stored and read back as 0. Each channel's ch_dir and ch_mag ports show its stored direction and magnitude.
- R2: After reset every channel reads direction 0 and magnitude 0, and sda_oe is 0.
- R3: In a write (START, device address with R/W=0, memory address, data byte, STOP) the slave pulls SDA low during the ninth clock of all three bytes. Channel settings change only as a result of such a data byte.
- R4: Channel k (k = 0..3) is written and read at memory address F8h + k.
- R5: A write to a memory address outside F8h..FBh is acknowledged and changes no channel. A read from such an address returns 00h.
- R6: A read (START, device address with R/W=1, one data byte, NACK, STOP) returns the register at the most recently received memory address. This pointer is F8h after reset.
- R7: When the first 7 bits after a START differ from dev_addr, the slave does not acknowledge. It ignores all bits until the next START.
- R8: Bytes move MSB first. The slave changes sda_oe only while SCL is low, apart from releasing it on an abort, START or STOP.
- R9: One clock after any change on dev_addr, sda_oe is 0 and the transaction is abandoned. Later bytes of that transaction are not acknowledged. The channel settings keep their values.
- R10: A repeated START without a STOP restarts address matching in the same way as a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_addr | input | 7 | Decoded 7-bit device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ch_dir | output | 4 | Per-channel direction, 1 = source |
| ch_mag | output | 20 | Per-channel 5-bit magnitude, channel k in bits 5k+4:5k |

## Verification
The assertions check four things on every cycle. The slave never drives SDA while a byte is coming in or while it is idle. sda_oe moves only while SCL is low, except on abort, START or STOP. A change of dev_addr clears the driver on the next clock. At most one channel is written at a time, and the settings stay constant unless a write strobe fires. The bench scenarios cover the rest. These are the address mapping, the reserved-bit masking, pointer-based reads, reads and writes to unmapped addresses, rejection of a foreign address, recovery through a repeated START, and an abort that lands in the middle of an acknowledge.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int MAG_W   = 5;
  localparam int DIR_BIT = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic scl_prev_q, sda_prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        scl_pipe_d = scl_i;
        sda_pipe_d = sda_i;
      end
    end else begin : g_many
      always_comb begin
        scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[SYNC_STAGES-1];
      sda_prev_q <= sda_pipe_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    scl_lvl   = scl_pipe_q[SYNC_STAGES-1];
    sda_lvl   = sda_pipe_q[SYNC_STAGES-1];
    scl_rise  = scl_lvl & ~scl_prev_q;
    scl_fall  = ~scl_lvl & scl_prev_q;
    bus_start = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    bus_stop  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import dacif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       abort,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       ptr_we,
  output logic       wr_en,
  output logic [7:0] rx_byte
);
  slv_state_e state_q, state_d;
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       oe_q, oe_d;
  logic       rw_q, rw_d;
  logic       last_bit;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    ptr_we   = 1'b0;
    wr_en    = 1'b0;
    rx_byte  = {sh_q[6:0], sda_lvl};
    last_bit = (cnt_q == 3'd7);
    if (abort) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (bus_start) begin
      state_d = ST_ADDR;
      cnt_d   = 3'd0;
      oe_d    = 1'b0;
    end else if (bus_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = rx_byte;
            cnt_d = cnt_q + 3'd1;
            if (last_bit) begin
              if (state_q == ST_ADDR) begin
                if (rx_byte[7:1] == dev_addr) begin
                  state_d = ST_ADDR_ACK;
                  rw_d    = rx_byte[0];
                end else begin
                  state_d = ST_IDLE;
                end
              end else if (state_q == ST_REG) begin
                ptr_we  = 1'b1;
                state_d = ST_REG_ACK;
              end else begin
                wr_en   = 1'b1;
                state_d = ST_WDATA_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_REG_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (!oe_q) begin
              oe_d = 1'b1;
            end else begin
              oe_d  = 1'b0;
              cnt_d = 3'd0;
              if (state_q == ST_ADDR_ACK) begin
                if (rw_q) begin
                  state_d = ST_RDATA;
                  sh_d    = rd_byte;
                  oe_d    = ~rd_byte[7];
                end else begin
                  state_d = ST_REG;
                end
              end else if (state_q == ST_REG_ACK) begin
                state_d = ST_WDATA;
              end else begin
                state_d = ST_IDLE;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 3'd1;
            if (last_bit) state_d = ST_RDATA_ACK;
          end else if (scl_fall) begin
            oe_d = ~sh_q[6];
            sh_d = {sh_q[6:0], 1'b0};
          end
        end
        ST_RDATA_ACK: begin
          if (scl_fall) oe_d = 1'b0;
          else if (scl_rise) state_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
      sh_q    <= 8'h00;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
    end
  end

  assign sda_oe = oe_q;

  // R3: no pull-down while a byte is coming in from the master
  a_r3_quiet_on_receive: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_ADDR, ST_REG, ST_WDATA}) |-> !oe_q);

  // R7: an idle or rejected slave leaves SDA alone
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);

  // R8: the pull-down is asserted only during SCL low
  a_r8_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !$past(scl_lvl));

  // R8: release happens during SCL low unless it is an abort or a bus condition
  a_r8_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> (!$past(scl_lvl) || $past(bus_start || bus_stop || abort)));
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dacif_pkg::*;
#(
  parameter int         NUM_CH = 4,
  parameter logic [7:0] BASE   = 8'hF8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ptr_we,
  input  logic                    wr_en,
  input  logic [7:0]              wdata,
  output logic [7:0]              rd_byte,
  output logic [NUM_CH-1:0]       ch_dir,
  output logic [NUM_CH*MAG_W-1:0] ch_mag
);
  logic [7:0]        ptr_q, ptr_d;
  logic [7:0]        offs;
  logic              hit;
  logic [NUM_CH-1:0] wsel;

  always_comb begin
    ptr_d = ptr_we ? wdata : ptr_q;
    offs  = ptr_q - BASE;
    hit   = (ptr_q >= BASE) && (offs < 8'(NUM_CH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= BASE;
    else        ptr_q <= ptr_d;
  end

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic             dir_q, dir_d;
      logic [MAG_W-1:0] mag_q, mag_d;
      assign wsel[k] = wr_en && hit && (offs == 8'(k));
      always_comb begin
        dir_d = wsel[k] ? wdata[DIR_BIT]   : dir_q;
        mag_d = wsel[k] ? wdata[MAG_W-1:0] : mag_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_q <= 1'b0;
          mag_q <= '0;
        end else begin
          dir_q <= dir_d;
          mag_q <= mag_d;
        end
      end
      assign ch_dir[k]              = dir_q;
      assign ch_mag[k*MAG_W +: MAG_W] = mag_q;
    end
  endgenerate

  always_comb begin
    rd_byte = 8'h00;
    for (int k = 0; k < NUM_CH; k++) begin
      if (hit && offs == 8'(k)) begin
        rd_byte[DIR_BIT]   = ch_dir[k];
        rd_byte[MAG_W-1:0] = ch_mag[k*MAG_W +: MAG_W];
      end
    end
  end

  // R4: a write strobe selects at most one channel
  a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));

  // R3: settings move only after a write strobe
  a_r3_change_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ch_dir) && $stable(ch_mag)));
endmodule

// File: rtl/dac_ctrl_i2c_slave.sv
module dac_ctrl_i2c_slave
  import dacif_pkg::*;
#(
  parameter int         NUM_CH      = 4,
  parameter logic [7:0] REG_BASE    = 8'hF8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [6:0]              dev_addr,
  output logic                    sda_oe,
  output logic [NUM_CH-1:0]       ch_dir,
  output logic [NUM_CH*MAG_W-1:0] ch_mag
);
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic       ptr_we, wr_en, abort;
  logic [7:0] rx_byte, rd_byte;
  logic [6:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= dev_addr;
  end
  assign abort = (dev_addr != addr_q);

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_slave_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .abort(abort), .dev_addr(dev_addr),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .ptr_we(ptr_we), .wr_en(wr_en),
    .rx_byte(rx_byte)
  );

  dac_reg_bank #(.NUM_CH(NUM_CH), .BASE(REG_BASE)) i_regs (
    .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .wr_en(wr_en),
    .wdata(rx_byte), .rd_byte(rd_byte), .ch_dir(ch_dir), .ch_mag(ch_mag)
  );

  // R9: an address-select change frees SDA on the following clock
  a_r9_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_addr != addr_q) |=> !sda_oe);
endmodule

// File: tb/test_dac_ctrl_i2c_slave.sv
module test_dac_ctrl_i2c_slave;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h4C;

  logic        clk = 1'b0;
  logic        rst_n, scl_m, sda_m;
  logic [6:0]  dev_addr;
  logic        sda_oe;
  logic [3:0]  ch_dir;
  logic [19:0] ch_mag;
  wire         sda_bus = sda_m & ~sda_oe;

  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [4];
  logic [7:0] mdl_ptr;

  always #2 clk = ~clk;

  dac_ctrl_i2c_slave i_dac_ctrl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_addr(dev_addr), .sda_oe(sda_oe), .ch_dir(ch_dir), .ch_mag(ch_mag)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] p);
    if (p >= 8'hF8 && p <= 8'hFB) return mdl[p - 8'hF8];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bstop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q/2); b = sda_bus; wt(Q/2); scl_m = 1'b0; wt(Q);
  endtask

  task automatic send8(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
  endtask

  task automatic wbyte(input logic [7:0] d, input logic exp_ack, input string req);
    logic a;
    send8(d);
    rbit(a);
    chk(req, a, exp_ack);
  endtask

  task automatic rbyte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(1'b1);
  endtask

  task automatic check_outputs(input string req);
    for (int k = 0; k < 4; k++) begin
      chk(req, ch_dir[k], mdl[k][7]);
      chk(req, ch_mag[k*5 +: 5], mdl[k][4:0]);
    end
  endtask

  task automatic reg_write(input logic [7:0] ra, input logic [7:0] d);
    bstart;
    wbyte({DEV, 1'b0}, 1'b0, "R3 addr ack");
    wbyte(ra, 1'b0, "R3/R5 reg ack");
    wbyte(d, 1'b0, "R3/R5 data ack");
    bstop;
    mdl_ptr = ra;
    if (ra >= 8'hF8 && ra <= 8'hFB) mdl[ra - 8'hF8] = d & 8'h9F;
  endtask

  task automatic reg_read(input logic [7:0] ra, input string req);
    logic [7:0] d;
    bstart;
    wbyte({DEV, 1'b0}, 1'b0, "R3 addr ack");
    wbyte(ra, 1'b0, "R6 ptr ack");
    bstart;
    wbyte({DEV, 1'b1}, 1'b0, "R10 read addr ack");
    rbyte(d);
    bstop;
    mdl_ptr = ra;
    chk(req, d, exp_read(ra));
  endtask

  task automatic read_cur(input string req);
    logic [7:0] d;
    bstart;
    wbyte({DEV, 1'b1}, 1'b0, "R6 read addr ack");
    rbyte(d);
    bstop;
    chk(req, d, exp_read(mdl_ptr));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, ra;
    logic a;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; dev_addr = DEV;
    for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
    mdl_ptr = 8'hF8;
    wt(5); rst_n = 1'b1; wt(5);

    // R2 reset state
    chk("R2 sda_oe", sda_oe, 1'b0);
    check_outputs("R2 reset channels");
    read_cur("R6 pointer after reset");

    // R1/R4 directed: reserved bits dropped, each address hits its channel
    reg_write(8'hF8, 8'h7F); check_outputs("R1 reserved bits");
    reg_read(8'hF8, "R1 readback masks bits 6:5");
    reg_write(8'hF9, 8'h92); reg_write(8'hFA, 8'h05); reg_write(8'hFB, 8'h9F);
    check_outputs("R4 channel map");
    read_cur("R6 read at last pointer FB");

    // R5 unmapped
    reg_write(8'hFC, 8'hFF); check_outputs("R5 unmapped write ignored");
    reg_read(8'hF7, "R5 unmapped read zero");
    read_cur("R5 unmapped pointer read");

    // R7 foreign address
    bstart;
    wbyte({DEV ^ 7'h10, 1'b0}, 1'b1, "R7 no ack on mismatch");
    wbyte(8'hF8, 1'b1, "R7 reg byte ignored");
    wbyte(8'h00, 1'b1, "R7 data byte ignored");
    bstop;
    check_outputs("R7 channels untouched");

    // R10 repeated START after a rejected address
    bstart;
    wbyte({DEV ^ 7'h01, 1'b1}, 1'b1, "R7 reject before restart");
    bstart;
    wbyte({DEV, 1'b1}, 1'b0, "R10 restart matches");
    rbyte(d);
    bstop;
    chk("R10 data after repeated START", d, exp_read(mdl_ptr));

    // R9 abort during the acknowledge of the register byte
    bstart;
    wbyte({DEV, 1'b0}, 1'b0, "R3 addr ack");
    send8(8'hF9);
    sda_m = 1'b1; wt(Q);
    chk("R3 slave pulling during ack", sda_oe, 1'b1);
    dev_addr = DEV ^ 7'h01; wt(2);
    chk("R9 sda released after address change", sda_oe, 1'b0);
    scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(Q);
    send8(8'h85); rbit(a);
    chk("R9 later byte not acked", a, 1'b1);
    dev_addr = DEV; wt(2);
    bstop;
    check_outputs("R9 settings kept after abort");

    // random mix, R8 MSB order checked through readback
    for (int it = 0; it < 28; it++) begin
      ra = 8'hF6 + 8'($urandom % 8);
      d  = 8'($urandom);
      reg_write(ra, d);
      check_outputs("R4 random write");
      ra = 8'hF6 + 8'($urandom % 8);
      reg_read(ra, "R8 random readback");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule